// File: doc/BRIEF.md
# Cascadable Timer Pair with Count Capture

This block holds two up-counters that each advance on a chosen count source: one of three pre-divided internal clock enables, or falling edges on a shared external event pin. A counter climbs from zero; the next count after it has reached its limit value returns it to zero and pulses its interrupt request for one clock cycle. The pair can be joined into one 16-bit counter whose limit is the two limit values taken together, the second counter holding the upper byte.

A capture mode copies the running count into a capture register on a rising edge of an external capture pin. The copy is 8 bits wide in split mode and 16 bits wide in joined mode. Each counter has a start pulse, which clears it and lets it run, and a hold level, which freezes it without clearing. The mode fields arrive as plain input levels from a register bank outside this block. The prescaler chain is outside as well.

Top module: `tmr_pair_capture`

## Requirements
- R1: In split mode a running, unheld counter adds one on each enabled tick of its source. A tick that arrives while the count equals its limit value sets the count to 0 instead, and drives the matching irq output high for exactly the following clock cycle. With limit D, one cycle of the count therefore takes D+1 ticks.
- R2: The 2-bit source select picks the source as follows: value 0, 1 or 2 picks bit 0, 1 or 2 of `tick_div`, and value 3 picks the external event pin.
- R3: The event pin passes through two synchronizing flops. Only a high-to-low change counts, and it is seen on the third rising clock edge after the low level is first present at a clock edge. A low-to-high change never counts.
- R4: Out of reset both counters are stopped. Ticks leave a stopped counter at 0. A start pulse clears its counter to 0 on that edge and lets it run afterwards, and a start takes priority over a tick on the same edge.
- R5: While the hold input of a started counter is high, its count stays at its value and is not cleared.
- R6: With `join16` high, {count_hi, count_lo} is one 16-bit counter. It uses counter 0's select, start and hold, and counts up to {limit_hi, limit_lo}. The next tick returns it to 0000 and pulses `irq1`. `irq0` stays low, and start1, hold1 and sel1 have no effect.
- R7: With `cap_en` high, a rising edge on `cap_pin` (two synchronizing flops; it loads on the third clock edge after the high level is first present) copies the count into `cap_val`. In split mode the copy is {8'h00, count_lo}; in joined mode it is {count_hi, count_lo}. The value copied is the count held just before that edge.
- R8: With `cap_en` low, `cap_val` keeps its value whatever `cap_pin` does.
- R9: After reset, both counts, both irq outputs and `cap_val` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div | input | 3 | Pre-divided internal clock enables |
| evt_pin | input | 1 | External event pin, asynchronous |
| cap_pin | input | 1 | External capture pin, asynchronous |
| sel0 | input | 2 | Source select, counter 0 |
| sel1 | input | 2 | Source select, counter 1 |
| join16 | input | 1 | Joins the pair into one 16-bit counter |
| cap_en | input | 1 | Enables capture |
| start0 | input | 1 | Start pulse, counter 0 |
| start1 | input | 1 | Start pulse, counter 1 |
| hold0 | input | 1 | Pause level, counter 0 |
| hold1 | input | 1 | Pause level, counter 1 |
| limit_lo | input | 8 | Limit value, counter 0 |
| limit_hi | input | 8 | Limit value, counter 1 |
| count_lo | output | 8 | Running count, counter 0 |
| count_hi | output | 8 | Running count, counter 1 |
| cap_val | output | 16 | Capture register |
| irq0 | output | 1 | Match pulse, counter 0 |
| irq1 | output | 1 | Match pulse, counter 1 or joined counter |

## Verification
Both counts are outputs, so a wrong increment, clear or hold shows up on the same edge it happens. A wrong match decision shows up as an early or missing return to zero, together with an irq pulse one cycle off. A wrong synchronizer depth or edge polarity moves a count or a capture by a cycle or more, and shows up at the first pin edge. A wrong capture path shows up in `cap_val` at the first capture edge. The bench runs a cycle-exact model and compares every output on every cycle, so any of these is reported within one cycle of its first visible effect.

// File: rtl/tmr_pair_capture.sv
module tmr_pair_capture #(
  parameter int W    = 8,
  parameter int SELW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2**SELW-2:0] tick_div,
  input  logic             evt_pin,
  input  logic             cap_pin,
  input  logic [SELW-1:0]  sel0,
  input  logic [SELW-1:0]  sel1,
  input  logic             join16,
  input  logic             cap_en,
  input  logic             start0,
  input  logic             start1,
  input  logic             hold0,
  input  logic             hold1,
  input  logic [W-1:0]     limit_lo,
  input  logic [W-1:0]     limit_hi,
  output logic [W-1:0]     count_lo,
  output logic [W-1:0]     count_hi,
  output logic [2*W-1:0]   cap_val,
  output logic             irq0,
  output logic             irq1
);
  localparam int NSRC = 2**SELW;

  logic [2:0] evt_s, cap_s;
  logic evt_fall, cap_rise;
  logic run0, run1;
  logic [NSRC-1:0] src_vec;
  logic tick0, tick1;
  logic [2*W-1:0] wide;

  assign evt_fall = evt_s[2] & ~evt_s[1];
  assign cap_rise = cap_s[1] & ~cap_s[2];
  assign src_vec  = {evt_fall, tick_div};
  assign tick0    = src_vec[sel0] & run0 & ~hold0;
  assign tick1    = src_vec[sel1] & run1 & ~hold1;
  assign wide     = {count_hi, count_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_s <= '1;
      cap_s <= '0;
    end else begin
      evt_s <= {evt_s[1:0], evt_pin};
      cap_s <= {cap_s[1:0], cap_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run0 <= 1'b0;
      run1 <= 1'b0;
      count_lo <= '0;
      count_hi <= '0;
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
      if (start0) run0 <= 1'b1;
      if (start1 && !join16) run1 <= 1'b1;
      if (join16) begin
        if (start0) begin
          {count_hi, count_lo} <= '0;
        end else if (tick0) begin
          if (wide == {limit_hi, limit_lo}) begin
            {count_hi, count_lo} <= '0;
            irq1 <= 1'b1;
          end else begin
            {count_hi, count_lo} <= wide + 1'b1;
          end
        end
      end else begin
        if (start0) count_lo <= '0;
        else if (tick0) begin
          if (count_lo == limit_lo) begin
            count_lo <= '0;
            irq0 <= 1'b1;
          end else count_lo <= count_lo + 1'b1;
        end
        if (start1) count_hi <= '0;
        else if (tick1) begin
          if (count_hi == limit_hi) begin
            count_hi <= '0;
            irq1 <= 1'b1;
          end else count_hi <= count_hi + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_val <= '0;
    else if (cap_en && cap_rise)
      cap_val <= join16 ? wide : {{W{1'b0}}, count_lo};
  end

  // R1
  irq0_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> count_lo == '0);
  // R1
  irq1_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> count_hi == '0);
  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start0 |=> count_lo == '0);
  // R5
  hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold0 && !start0 && !join16) |=> $stable(count_lo));
  // R6
  joined_irq0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    join16 |=> !irq0);
  // R8
  cap_off_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_val));
endmodule

// File: tb/tmr_pair_capture_test.sv
module tmr_pair_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] tick_div = '0;
  logic evt_pin = 1'b1, cap_pin = 1'b0;
  logic [1:0] sel0 = '0, sel1 = '0;
  logic join16 = 1'b0, cap_en = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0, hold0 = 1'b0, hold1 = 1'b0;
  logic [7:0] limit_lo = 8'd1, limit_hi = 8'd1;
  logic [7:0] count_lo, count_hi;
  logic [15:0] cap_val;
  logic irq0, irq1;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  logic [7:0] m_lo, m_hi;
  logic [15:0] m_cap;
  logic m_irq0, m_irq1, m_run0, m_run1;
  logic [2:0] me, mc;

  always #5 clk = ~clk;

  tmr_pair_capture uut (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .evt_pin(evt_pin),
    .cap_pin(cap_pin), .sel0(sel0), .sel1(sel1), .join16(join16),
    .cap_en(cap_en), .start0(start0), .start1(start1), .hold0(hold0),
    .hold1(hold1), .limit_lo(limit_lo), .limit_hi(limit_hi),
    .count_lo(count_lo), .count_hi(count_hi), .cap_val(cap_val),
    .irq0(irq0), .irq1(irq1));

  function automatic logic pick(input logic [1:0] s, input logic ef);
    return (s == 2'd3) ? ef : tick_div[s];
  endfunction

  task automatic model_step();
    logic ef, cr, t0, t1;
    logic [15:0] w;
    ef = me[2] & ~me[1];
    cr = mc[1] & ~mc[2];
    me = {me[1:0], evt_pin};
    mc = {mc[1:0], cap_pin};
    w = {m_hi, m_lo};
    t0 = pick(sel0, ef) & m_run0 & ~hold0;
    t1 = pick(sel1, ef) & m_run1 & ~hold1;
    if (cap_en && cr) m_cap = join16 ? w : {8'h00, m_lo};
    m_irq0 = 1'b0;
    m_irq1 = 1'b0;
    if (join16) begin
      if (start0) w = '0;
      else if (t0) begin
        if (w == {limit_hi, limit_lo}) begin w = '0; m_irq1 = 1'b1; end
        else w = w + 16'd1;
      end
      m_lo = w[7:0];
      m_hi = w[15:8];
    end else begin
      if (start0) m_lo = '0;
      else if (t0) begin
        if (m_lo == limit_lo) begin m_lo = '0; m_irq0 = 1'b1; end
        else m_lo = m_lo + 8'd1;
      end
      if (start1) m_hi = '0;
      else if (t1) begin
        if (m_hi == limit_hi) begin m_hi = '0; m_irq1 = 1'b1; end
        else m_hi = m_hi + 8'd1;
      end
    end
    if (start0) m_run0 = 1'b1;
    if (start1 && !join16) m_run1 = 1'b1;
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "count_lo", {8'h00, count_lo}, {8'h00, m_lo});
    chk(tag, "count_hi", {8'h00, count_hi}, {8'h00, m_hi});
    chk(tag, "cap_val", cap_val, m_cap);
    chk(tag, "irq0", {15'd0, irq0}, {15'd0, m_irq0});
    chk(tag, "irq1", {15'd0, irq1}, {15'd0, m_irq1});
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    cycles++;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic pulse_start(input bit a, input bit b, input string tag);
    start0 = a;
    start1 = b;
    cyc(tag);
    start0 = 1'b0;
    start1 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_lo = '0; m_hi = '0; m_cap = '0; m_irq0 = 1'b0; m_irq1 = 1'b0;
    m_run0 = 1'b0; m_run1 = 1'b0; me = 3'b111; mc = 3'b000;
    repeat (3) @(negedge clk);
    // R9 reset state
    compare_all("R9");
    rst_n = 1'b1;

    // R4 stopped counters ignore ticks
    for (int i = 0; i < 10; i++) begin
      tick_div = 3'($urandom);
      cyc("R4");
    end

    // R1 directed: limit 3, tick every cycle
    limit_lo = 8'd3; limit_hi = 8'd5; sel0 = 2'd0; sel1 = 2'd1;
    tick_div = 3'b011;
    pulse_start(1'b1, 1'b1, "R4");
    for (int i = 0; i < 20; i++) cyc("R1");
    // R4 start and tick on same edge
    pulse_start(1'b1, 1'b0, "R4");
    for (int i = 0; i < 3; i++) cyc("R1");

    // R5 hold
    hold0 = 1'b1; hold1 = 1'b1;
    for (int i = 0; i < 6; i++) cyc("R5");
    hold0 = 1'b0; hold1 = 1'b0;
    for (int i = 0; i < 4; i++) cyc("R5");

    // R2 random sources and limits, split mode
    for (int i = 0; i < 3000; i++) begin
      tick_div = 3'($urandom);
      sel0 = 2'($urandom_range(0, 2));
      sel1 = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 99) == 0) limit_lo = 8'($urandom_range(1, 12));
      if ($urandom_range(0, 99) == 0) limit_hi = 8'($urandom_range(1, 12));
      hold0 = ($urandom_range(0, 7) == 0);
      hold1 = ($urandom_range(0, 7) == 0);
      start0 = ($urandom_range(0, 199) == 0);
      start1 = ($urandom_range(0, 199) == 0);
      cyc("R2");
    end
    start0 = 1'b0; start1 = 1'b0; hold0 = 1'b0; hold1 = 1'b0;

    // R3 external event source, both counters
    sel0 = 2'd3; sel1 = 2'd3; limit_lo = 8'd4; limit_hi = 8'd6;
    for (int i = 0; i < 2000; i++) begin
      tick_div = 3'($urandom);
      if ($urandom_range(0, 3) == 0) evt_pin = ~evt_pin;
      cyc("R3");
    end
    evt_pin = 1'b1;

    // R6 joined counter, wrap at {1,5} = 261
    join16 = 1'b1; sel0 = 2'd0; sel1 = 2'd3; tick_div = 3'b001;
    limit_lo = 8'd5; limit_hi = 8'd1;
    pulse_start(1'b1, 1'b0, "R6");
    for (int i = 0; i < 600; i++) begin
      hold1 = ($urandom_range(0, 3) == 0);
      start1 = ($urandom_range(0, 30) == 0);
      cyc("R6");
    end
    start1 = 1'b0; hold1 = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      tick_div = 3'($urandom);
      sel0 = 2'($urandom_range(0, 2));
      hold0 = ($urandom_range(0, 7) == 0);
      cyc("R6");
    end
    hold0 = 1'b0;

    // R7 capture in joined then split mode
    cap_en = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      tick_div = 3'($urandom);
      if ($urandom_range(0, 4) == 0) cap_pin = ~cap_pin;
      cyc("R7");
    end
    join16 = 1'b0; limit_lo = 8'd200; sel0 = 2'd0;
    pulse_start(1'b1, 1'b1, "R7");
    for (int i = 0; i < 1500; i++) begin
      tick_div = 3'($urandom);
      if ($urandom_range(0, 4) == 0) cap_pin = ~cap_pin;
      cyc("R7");
    end

    // R8 capture disabled
    cap_en = 1'b0;
    for (int i = 0; i < 500; i++) begin
      tick_div = 3'($urandom);
      if ($urandom_range(0, 2) == 0) cap_pin = ~cap_pin;
      cyc("R8");
    end

    finish_run();
  end
endmodule